// File: doc/BRIEF.md
# External Interrupt Pin Sense and Wake Conditioner

This block turns a set of active-low external interrupt request pins into clean pending flags for an interrupt controller, and raises a wake request toward a clock-control unit while the core sleeps. Each pin has its own enable and its own sense selection: low-level or falling-edge. In normal operation each pin is brought into the clock domain by a synchronizer chain. A falling edge is found by comparing the synchronized value with the value one cycle older.

When the sleep indicator is high, the clock may be stopped. Every pin is then treated as low-level sensitive, whatever its sense bit holds, and the edge detector stops setting flags. The wake output is formed without any register between the raw pins and the output. Only a pin whose enable was already set before sleep began can raise it. Configuration writes are refused while asleep, so the enables present at sleep entry govern wake.

Top module: `xirq_sense`

## Requirements
- R1: After reset, all enables are clear, every pin is in level mode, `pend_o` is all zero, and `wake_o` stays low even with the pins low and `sleep_i` high.
- R2: In level mode (sense bit 0) and awake, `pend_o[i]` is high while pin i is low and enabled, and it drops again when the pin returns high. No acknowledge is needed.
- R3: In edge mode (sense bit 1) and awake, a high-to-low transition on an enabled pin sets `pend_o[i]`. The flag stays set after the pin returns high, and `ack_i[i]` clears it.
- R4: In edge mode, a pin held low after its flag has been acknowledged does not set the flag again until it rises and falls once more.
- R5: A pin whose enable bit is 0 never raises `pend_o` or `wake_o`.
- R6: While `sleep_i` is high, an enabled pin in edge mode behaves as level sensitive, and no new edge flag is set.
- R7: While `sleep_i` is high, `wake_o` follows an enabled raw pin within the same cycle, with no clock edge in between.
- R8: Writes to `cfg_wdata_i` made while `sleep_i` is high have no effect. The enables and sense bits from before sleep stay in force during sleep and after it ends.
- R9: `wake_o` is low whenever `sleep_i` is low.
- R10: An edge flag set before sleep starts raises `wake_o` as soon as `sleep_i` rises, even with the pin high. Acknowledging the flag removes the request.
- R11: The pins are independent: each has its own enable (control bit i) and its own sense bit (control bit NUM_PINS+i, 1 = falling edge). Pin 0 is the least significant bit of every vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| irq_n_i | input | NUM_PINS | Raw external request pins, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 2*NUM_PINS | Control write data: enables in the low half, sense bits in the high half |
| sleep_i | input | 1 | Core is in Wait or Stop |
| ack_i | input | NUM_PINS | Per-pin acknowledge for edge flags |
| pend_o | output | NUM_PINS | Pending request per pin |
| wake_o | output | 1 | Wake request to the clock-control unit |

## Verification
The assertions assume that `ack_i` is only raised for a pin the controller has seen pending. They also assume that `cfg_we_i` is not relied on to change the configuration while `sleep_i` is high, and that reset is held for at least as many cycles as the synchronizer has stages. The stimulus changes pins, writes and `sleep_i` only on falling clock edges. It holds every pin level for at least four cycles before sampling, so each synchronized value settles before a flag is judged. The only exception is the wake checks, which sample one nanosecond after a pin change to show the path has no clock in it.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

   typedef enum logic {
      SENSE_LEVEL = 1'b0,
      SENSE_FALL  = 1'b1
   } sense_e;

   // Sleep overrides the programmed sense to level
   function automatic logic level_active(input logic sense_bit, input logic sleep);
      return (sense_bit == SENSE_LEVEL) || sleep;
   endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) chain_q <= {STAGES{RST_VAL}};
      else       chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
   parameter int NUM_PINS = 2,
   localparam int CFG_W   = 2 * NUM_PINS
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                we_i,
   input  logic [CFG_W-1:0]    wdata_i,
   input  logic                sleep_i,
   output logic [NUM_PINS-1:0] en_o,
   output logic [NUM_PINS-1:0] sense_o
);
   logic [NUM_PINS-1:0] en_q, sense_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         en_q    <= '0;
         sense_q <= '0;
      end else if (we_i && !sleep_i) begin
         en_q    <= wdata_i[NUM_PINS-1:0];
         sense_q <= wdata_i[CFG_W-1:NUM_PINS];
      end
   end

   assign en_o    = en_q;
   assign sense_o = sense_q;
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
   import xirq_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic sync_i,
   input  logic en_i,
   input  logic sense_i,
   input  logic sleep_i,
   input  logic ack_i,
   output logic pend_o,
   output logic flag_o
);
   logic prev_q, flag_q, fall, use_level;

   assign fall      = prev_q && !sync_i;
   assign use_level = level_active(sense_i, sleep_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prev_q <= 1'b1;
         flag_q <= 1'b0;
      end else begin
         prev_q <= sync_i;
         if (!sleep_i && sense_i == SENSE_FALL && en_i && fall)
            flag_q <= 1'b1;
         else if (ack_i || !en_i || (sense_i == SENSE_LEVEL && !sleep_i))
            flag_q <= 1'b0;
      end
   end

   assign pend_o = use_level ? ((en_i && !sync_i) || flag_q) : flag_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense #(
   parameter int NUM_PINS    = 2,
   parameter int SYNC_STAGES = 2,
   localparam int CFG_W      = 2 * NUM_PINS
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic [NUM_PINS-1:0] irq_n_i,
   input  logic                cfg_we_i,
   input  logic [CFG_W-1:0]    cfg_wdata_i,
   input  logic                sleep_i,
   input  logic [NUM_PINS-1:0] ack_i,
   output logic [NUM_PINS-1:0] pend_o,
   output logic                wake_o
);
   if (NUM_PINS < 1 || SYNC_STAGES < 2) begin : g_bad_cfg
      $error("xirq_sense: NUM_PINS must be >= 1 and SYNC_STAGES >= 2");
   end

   logic [NUM_PINS-1:0] en_w, sense_w, sync_w, flag_w;

   xirq_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .we_i    (cfg_we_i),
      .wdata_i (cfg_wdata_i),
      .sleep_i (sleep_i),
      .en_o    (en_w),
      .sense_o (sense_w)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      xirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk_i (clk_i),
         .rst_i (rst_i),
         .d_i   (irq_n_i[i]),
         .q_o   (sync_w[i])
      );
      xirq_chan u_chan (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .sync_i  (sync_w[i]),
         .en_i    (en_w[i]),
         .sense_i (sense_w[i]),
         .sleep_i (sleep_i),
         .ack_i   (ack_i[i]),
         .pend_o  (pend_o[i]),
         .flag_o  (flag_w[i])
      );
   end

   // Clockless wake path: raw pins, gated by enables latched before sleep
   assign wake_o = sleep_i && (|(en_w & (~irq_n_i | flag_w)));
endmodule

// File: rtl/xirq_sense_chk.sv
module xirq_sense_chk #(
   parameter int NUM_PINS = 2
) (
   input logic                clk,
   input logic                rst,
   input logic                sleep,
   input logic                wr_en,
   input logic [NUM_PINS-1:0] ack,
   input logic [NUM_PINS-1:0] en,
   input logic [NUM_PINS-1:0] sense,
   input logic [NUM_PINS-1:0] sync,
   input logic [NUM_PINS-1:0] pend,
   input logic                wake
);
   assert_wake_awake_low_R9: assert property (@(posedge clk) disable iff (rst)
      !sleep |-> !wake);

   assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
      (sleep && $past(sleep)) |-> ($stable(en) && $stable(sense)));

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
      assert_sleep_level_R6: assert property (@(posedge clk) disable iff (rst)
         (sleep && en[i] && !sync[i]) |-> pend[i]);

      assert_edge_hold_R3: assert property (@(posedge clk) disable iff (rst)
         (sense[i] && en[i] && !sleep && pend[i] && !ack[i] && !wr_en) |=> pend[i]);
   end
endmodule

bind xirq_sense xirq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk   (clk_i),
   .rst   (rst_i),
   .sleep (sleep_i),
   .wr_en (cfg_we_i),
   .ack   (ack_i),
   .en    (en_w),
   .sense (sense_w),
   .sync  (sync_w),
   .pend  (pend_o),
   .wake  (wake_o)
);

// File: tb/xirq_sense_tb.sv
module xirq_sense_tb;
   localparam int NP = 2;

   logic          clk = 1'b0;
   logic          rst;
   logic [NP-1:0] irq_n;
   logic          we;
   logic [2*NP-1:0] wdata;
   logic          sleep;
   logic [NP-1:0] ack;
   logic [NP-1:0] pend;
   logic          wake;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   xirq_sense #(.NUM_PINS(NP), .SYNC_STAGES(2)) u_dut (
      .clk_i(clk), .rst_i(rst), .irq_n_i(irq_n), .cfg_we_i(we),
      .cfg_wdata_i(wdata), .sleep_i(sleep), .ack_i(ack),
      .pend_o(pend), .wake_o(wake)
   );

   // {cfg[3:0] = {senseB,senseA,enB,enA}, irq_n[1:0] = {B,A}, expected pend {B,A}}
   localparam logic [7:0] VEC [10] = '{
      8'h00, 8'h33, 8'h3C, 8'h11, 8'h22,
      8'h7C, 8'h79, 8'h7D, 8'h77, 8'h7D
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [2*NP-1:0] d);
      we = 1'b1; wdata = d;
      step(1);
      we = 1'b0;
   endtask

   task automatic pulse_ack(input logic [NP-1:0] m);
      ack = m;
      step(1);
      ack = '0;
   endtask

   initial begin
      rst = 1'b1; irq_n = '1; we = 1'b0; wdata = '0; sleep = 1'b0; ack = '0;
      step(3);
      rst = 1'b0;
      step(1);
      check("R1", pend, 2'b00);
      check("R1", {1'b0, wake}, 2'b00);
      irq_n = '0; sleep = 1'b1;
      step(4);
      check("R1", pend, 2'b00);
      check("R5", {1'b0, wake}, 2'b00);
      sleep = 1'b0; irq_n = '1;
      step(4);

      // Vector table: level/edge sensing, enables, pin independence (R2 R3 R5 R11)
      for (int k = 0; k < 10; k++) begin
         irq_n = VEC[k][3:2];
         write_cfg(VEC[k][7:4]);
         step(4);
         check("R2/R3/R5/R11 table", pend, VEC[k][1:0]);
      end

      // R3: acknowledge clears the held edge flag
      pulse_ack(2'b01);
      step(3);
      check("R3", pend, 2'b00);
      // R4: held low after ack does not set again
      irq_n = 2'b10;
      step(4);
      check("R3", pend, 2'b01);
      pulse_ack(2'b01);
      step(4);
      check("R4", pend, 2'b00);
      irq_n = 2'b11;
      step(4);

      // Sleep: level override and clockless wake
      write_cfg(4'b0101);
      step(3);
      sleep = 1'b1;
      step(1);
      irq_n = 2'b10;
      #1 check("R7", {1'b0, wake}, 2'b01);
      step(4);
      check("R6", pend, 2'b01);
      irq_n = 2'b11;
      #1 check("R7", {1'b0, wake}, 2'b00);
      step(4);
      check("R6", pend, 2'b00);

      // R8: write during sleep refused
      write_cfg(4'b0000);
      irq_n = 2'b10;
      #1 check("R8", {1'b0, wake}, 2'b01);
      step(1);
      irq_n = 2'b11;
      step(3);
      sleep = 1'b0;
      step(2);
      irq_n = 2'b10;
      step(4);
      check("R8", pend, 2'b01);
      check("R9", {1'b0, wake}, 2'b00);
      irq_n = 2'b11;
      step(4);
      check("R3", pend, 2'b01);

      // R10: flag captured before sleep wakes at once
      sleep = 1'b1;
      #1 check("R10", {1'b0, wake}, 2'b01);
      pulse_ack(2'b01);
      check("R10", {1'b0, wake}, 2'b00);
      check("R10", pend, 2'b00);
      sleep = 1'b0;
      step(2);

      // Mid-run reset
      write_cfg(4'b0011);
      irq_n = 2'b00;
      step(4);
      check("R2", pend, 2'b11);
      rst = 1'b1;
      step(2);
      rst = 1'b0;
      step(4);
      check("R1", pend, 2'b00);
      sleep = 1'b1;
      #1 check("R1", {1'b0, wake}, 2'b00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule